// File: doc/BRIEF.md
# SD Data FIFO with Thresholds

A word-wide staging buffer between a processor data port and the serial data-line engine of an SD host. Data flows one way per transfer. In a card-to-processor transfer the line engine pushes words in and the processor pops them. In a processor-to-card transfer the processor pushes and the line engine pops. A debug/status word exposes the current fill level and two programmable 5-bit thresholds. A data-request flag tells the processor when a burst of words can be moved.

Transfer length is set when the transfer starts, as a block size in bytes and a block count. The block counts words on the line-engine side. It raises a sticky block-complete flag at the end of every block and a done flag once the last block has passed. Misuse of the buffer sets a sticky error flag and changes no storage. Misuse means popping while it is empty or pushing while it is full.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the fill level is 0, both thresholds are 4, `dbg_rdata_o` reads 0x0001_0800, and `data_req_o`, `blk_irq_o`, `fifo_err_o` and `xfer_done_o` are 0.
- R2: `dbg_rdata_o` carries the fill level in bits 8:4, the write threshold in bits 13:9 and the read threshold in bits 18:14; all other bits read 0. Writing with `dbg_we_i` loads only the two threshold fields, so writing all ones reads back 0x0007_FE00 when the buffer is empty.
- R3: Words leave in the order they entered. The buffer holds up to 16 words, and every accepted push or pop changes the fill level by one. Popped data appears on `cpu_rdata_o` / `st_data_o` one cycle after the pop strobe.
- R4: A pop while empty leaves the read data at the last popped value and sets the error flag. A push while full leaves the fill level unchanged and sets the error flag. In both cases no pointer moves.
- R5: `fifo_err_o` stays set until `err_clr_i` is pulsed. A new error in the same cycle wins over the clear.
- R6: In card-to-processor mode (`dir_read_i`=1), `data_req_o` is 1 when the fill is nonzero and either the fill is at least the read threshold or the fill covers every word of the current block that the processor has not yet read.
- R7: In processor-to-card mode (`dir_read_i`=0), `data_req_o` is 1 while blocks remain and the free space (16 minus fill) is at least the write threshold.
- R8: After `blk_size_i`/4 line-side words, `blk_irq_o` sets and stays set until `blk_clr_i`. Once `blk_cnt_i` blocks have passed, `xfer_done_o` is 1. Line-side strobes while no blocks remain are ignored.
- R9: In card-to-processor mode, `cpu_wr_i` and `st_pop_i` are ignored. In processor-to-card mode, `st_push_i` and `cpu_rd_i` are ignored.
- R10: `start_i` empties the buffer, loads the block size and count, and clears `xfer_done_o`. A block count of 0 starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_read_i | input | 1 | 1 = card to processor, 0 = processor to card; hold during a transfer |
| start_i | input | 1 | Begin a transfer: flush, load size and count |
| blk_size_i | input | BSZ_W | Block size in bytes, multiple of 4 |
| blk_cnt_i | input | BCNT_W | Number of blocks |
| cpu_wr_i | input | 1 | Processor push strobe |
| cpu_wdata_i | input | DW | Processor push data |
| cpu_rd_i | input | 1 | Processor pop strobe |
| cpu_rdata_o | output | DW | Last popped word |
| st_push_i | input | 1 | Line-side push strobe |
| st_data_i | input | DW | Line-side push data |
| st_pop_i | input | 1 | Line-side pop strobe |
| st_data_o | output | DW | Last popped word |
| dbg_we_i | input | 1 | Write the threshold fields |
| dbg_wdata_i | input | 32 | Debug word write data |
| dbg_rdata_o | output | 32 | Fill level and thresholds |
| blk_clr_i | input | 1 | Clear block-complete flag |
| err_clr_i | input | 1 | Clear error flag |
| data_req_o | output | 1 | Processor may move a burst |
| blk_irq_o | output | 1 | Sticky block complete |
| fifo_err_o | output | 1 | Sticky misuse error |
| xfer_done_o | output | 1 | All blocks passed |

## Verification
The read-direction test crosses a two-block transfer and separates three cases of the request flag: fill below threshold, fill at threshold, and a short tail that meets only the remaining-words rule. The write-direction test fills the buffer to 12, 13 and 16 words, which shows where free space crosses the write threshold. It then pushes once more to confirm the full-push error. Strobes from the inactive side and strobes after the last block are sent while the fill level is known, so an ignored strobe shows up as an unchanged count. A pop from an empty buffer after a known last word tells a held read value apart from stale or fresh memory data.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int unsigned THR_W    = 5;
  localparam int unsigned FILL_LSB = 4;
  localparam int unsigned WTHR_LSB = 9;
  localparam int unsigned RTHR_LSB = 14;
  localparam logic [THR_W-1:0] THR_RST = 5'd4;
endpackage

// File: rtl/sdf_mem.sv
module sdf_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] fill_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full_o  = (fill_o == CW'(DEPTH));
  assign empty_o = (fill_o == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      fill_o  <= '0;
      rdata_o <= '0;
    end else if (flush_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_o <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop) begin
        rp_q    <= rp_q + AW'(1);
        rdata_o <= mem[rp_q];
      end
      case ({do_push, do_pop})
        2'b10:   fill_o <= fill_o + CW'(1);
        2'b01:   fill_o <= fill_o - CW'(1);
        default: ;
      endcase
    end
  end

  a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CW'(DEPTH));
  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (fill_o == CW'(DEPTH)));
  a_r4_empty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(rdata_o));
endmodule

// File: rtl/sdf_word_ctr.sv
module sdf_word_ctr #(
  parameter int unsigned WW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] len_i,
  input  logic          step_i,
  output logic [WW-1:0] left_o,
  output logic          wrap_o
);
  assign wrap_o = step_i && !load_i && (left_o <= WW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        left_o <= '0;
    else if (load_i)    left_o <= len_i;
    else if (wrap_o)    left_o <= len_i;
    else if (step_i)    left_o <= left_o - WW'(1);
  end

  a_r8_left_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (left_o <= len_i) || ($past(left_o) == left_o));
endmodule

// File: rtl/sdf_req.sv
module sdf_req
  import sdf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned WW    = 12
) (
  input  logic             dir_read_i,
  input  logic             active_i,
  input  logic [CW-1:0]    fill_i,
  input  logic [THR_W-1:0] rd_thr_i,
  input  logic [THR_W-1:0] wr_thr_i,
  input  logic [WW-1:0]    cpu_left_i,
  output logic             req_o
);
  int unsigned fill_n, free_n;
  logic rd_req, wr_req;

  always_comb begin
    fill_n = int'(fill_i);
    free_n = DEPTH - fill_n;
    rd_req = (fill_n != 0) &&
             ((fill_n >= int'(rd_thr_i)) || (fill_n >= int'(cpu_left_i)));
    wr_req = active_i && (free_n >= int'(wr_thr_i));
    req_o  = dir_read_i ? rd_req : wr_req;
  end
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sdf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned BSZ_W  = 12,
  parameter int unsigned BCNT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_read_i,
  input  logic              start_i,
  input  logic [BSZ_W-1:0]  blk_size_i,
  input  logic [BCNT_W-1:0] blk_cnt_i,
  input  logic              cpu_wr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              st_push_i,
  input  logic [DW-1:0]     st_data_i,
  input  logic              st_pop_i,
  output logic [DW-1:0]     st_data_o,
  input  logic              dbg_we_i,
  input  logic [31:0]       dbg_wdata_i,
  output logic [31:0]       dbg_rdata_o,
  input  logic              blk_clr_i,
  input  logic              err_clr_i,
  output logic              data_req_o,
  output logic              blk_irq_o,
  output logic              fifo_err_o,
  output logic              xfer_done_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam int unsigned WW = BSZ_W;

  logic [WW-1:0]     blk_words_q, st_left, cpu_left;
  logic [BCNT_W-1:0] blocks_q;
  logic [THR_W-1:0]  rd_thr_q, wr_thr_q;
  logic [CW-1:0]     fill;
  logic [DW-1:0]     rdata, wdata;
  logic              full, empty, active, push, pop, misuse;
  logic              st_step, cpu_step, blk_end, unused_cpu_wrap;
  logic              unused_dbg;

  assign unused_dbg = ^{dbg_wdata_i[31:RTHR_LSB+THR_W], dbg_wdata_i[WTHR_LSB-1:0]};

  assign active = (blocks_q != '0);
  // direction picks which side feeds and which side drains
  assign push   = dir_read_i ? (st_push_i && active) : cpu_wr_i;
  assign pop    = dir_read_i ? cpu_rd_i : (st_pop_i && active);
  assign wdata  = dir_read_i ? st_data_i : cpu_wdata_i;
  assign misuse = !start_i && ((push && full) || (pop && empty));

  assign st_step  = !start_i && (dir_read_i ? (push && !full) : (pop && !empty));
  assign cpu_step = !start_i && dir_read_i && pop && !empty;

  sdf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i, .rst_ni, .flush_i(start_i), .push_i(push), .pop_i(pop),
    .wdata_i(wdata), .rdata_o(rdata), .fill_o(fill), .full_o(full), .empty_o(empty)
  );

  sdf_word_ctr #(.WW(WW)) u_st_ctr (
    .clk_i, .rst_ni, .load_i(start_i), .len_i(start_i ? (blk_size_i >> 2) : blk_words_q),
    .step_i(st_step), .left_o(st_left), .wrap_o(blk_end)
  );

  sdf_word_ctr #(.WW(WW)) u_cpu_ctr (
    .clk_i, .rst_ni, .load_i(start_i), .len_i(start_i ? (blk_size_i >> 2) : blk_words_q),
    .step_i(cpu_step), .left_o(cpu_left), .wrap_o(unused_cpu_wrap)
  );

  sdf_req #(.DEPTH(DEPTH), .CW(CW), .WW(WW)) u_req (
    .dir_read_i, .active_i(active), .fill_i(fill), .rd_thr_i(rd_thr_q),
    .wr_thr_i(wr_thr_q), .cpu_left_i(cpu_left), .req_o(data_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_words_q <= '0;
      blocks_q    <= '0;
      rd_thr_q    <= THR_RST;
      wr_thr_q    <= THR_RST;
      blk_irq_o   <= 1'b0;
      fifo_err_o  <= 1'b0;
      xfer_done_o <= 1'b0;
    end else begin
      if (dbg_we_i) begin
        rd_thr_q <= dbg_wdata_i[RTHR_LSB +: THR_W];
        wr_thr_q <= dbg_wdata_i[WTHR_LSB +: THR_W];
      end
      if (start_i) begin
        blk_words_q <= blk_size_i >> 2;
        blocks_q    <= blk_cnt_i;
        xfer_done_o <= 1'b0;
      end else if (blk_end) begin
        blocks_q <= blocks_q - BCNT_W'(1);
        if (blocks_q == BCNT_W'(1)) xfer_done_o <= 1'b1;
      end
      if (blk_end)        blk_irq_o <= 1'b1;
      else if (blk_clr_i) blk_irq_o <= 1'b0;
      if (misuse)         fifo_err_o <= 1'b1;
      else if (err_clr_i) fifo_err_o <= 1'b0;
    end
  end

  assign cpu_rdata_o = rdata;
  assign st_data_o   = rdata;

  always_comb begin
    dbg_rdata_o = '0;
    dbg_rdata_o[FILL_LSB +: THR_W] = THR_W'(fill);
    dbg_rdata_o[WTHR_LSB +: THR_W] = wr_thr_q;
    dbg_rdata_o[RTHR_LSB +: THR_W] = rd_thr_q;
  end

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_err_o && !err_clr_i) |=> fifo_err_o);
  a_r4_empty_pop_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && empty && !start_i) |=> fifo_err_o);
  a_r8_blocks_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (blocks_q <= $past(blocks_q)));
  a_r8_done_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> (blocks_q == '0));
  a_r10_start_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (fill == '0) && !xfer_done_o);
endmodule

// File: tb/sim_sd_data_fifo.sv
module sim_sd_data_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic dir_read = 1, start = 0;
  logic [11:0] blk_size = '0;
  logic [8:0]  blk_cnt = '0;
  logic cpu_wr = 0, cpu_rd = 0, st_push = 0, st_pop = 0;
  logic [31:0] cpu_wdata = '0, st_dat_in = '0, dbg_wdata = '0;
  logic dbg_we = 0, blk_clr = 0, err_clr = 0;
  logic [31:0] cpu_rdata, st_dat_out, dbg_rdata;
  logic data_req, blk_irq, fifo_err, xfer_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_data_fifo u0 (
    .clk_i(clk), .rst_ni, .dir_read_i(dir_read), .start_i(start),
    .blk_size_i(blk_size), .blk_cnt_i(blk_cnt),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .cpu_rdata_o(cpu_rdata),
    .st_push_i(st_push), .st_data_i(st_dat_in), .st_pop_i(st_pop), .st_data_o(st_dat_out),
    .dbg_we_i(dbg_we), .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
    .blk_clr_i(blk_clr), .err_clr_i(err_clr), .data_req_o(data_req),
    .blk_irq_o(blk_irq), .fifo_err_o(fifo_err), .xfer_done_o(xfer_done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fill_of();
    return 32'((dbg_rdata >> 4) & 32'h1f);
  endfunction

  task automatic step(); @(negedge clk); endtask
  task automatic st_in(logic [31:0] d);
    st_push = 1; st_dat_in = d; step(); st_push = 0;
  endtask
  task automatic cpu_in(logic [31:0] d);
    cpu_wr = 1; cpu_wdata = d; step(); cpu_wr = 0;
  endtask
  task automatic cpu_out(); cpu_rd = 1; step(); cpu_rd = 0; endtask
  task automatic st_out();  st_pop = 1; step(); st_pop = 0; endtask
  task automatic begin_xfer(logic dr, logic [11:0] sz, logic [8:0] n);
    dir_read = dr; blk_size = sz; blk_cnt = n; start = 1; step(); start = 0;
  endtask

  task automatic t_reset();
    chk("R1 dbg", dbg_rdata, 32'h0001_0800);
    chk("R1 req", 32'(data_req), 0);
    chk("R1 blk", 32'(blk_irq), 0);
    chk("R1 err", 32'(fifo_err), 0);
    chk("R1 done", 32'(xfer_done), 0);
  endtask

  task automatic t_dbg();
    dbg_we = 1; dbg_wdata = 32'hFFFF_FFFF; step(); dbg_we = 0;
    chk("R2 all ones", dbg_rdata, 32'h0007_FE00);
    dbg_we = 1; dbg_wdata = (32'd4 << 14) | (32'd4 << 9); step(); dbg_we = 0;
    chk("R2 restore", dbg_rdata, 32'h0001_0800);
  endtask

  task automatic t_read_mode();
    begin_xfer(1'b1, 12'd32, 9'd2);
    for (int i = 0; i < 3; i++) st_in(32'hA000_0000 + i);
    chk("R3 fill 3", fill_of(), 3);
    chk("R6 below thr", 32'(data_req), 0);
    st_in(32'hA000_0003);
    chk("R6 at thr", 32'(data_req), 1);
    for (int i = 0; i < 4; i++) begin
      cpu_out();
      chk("R3 order", cpu_rdata, 32'hA000_0000 + i);
    end
    chk("R6 empty", 32'(data_req), 0);
    for (int i = 4; i < 8; i++) st_in(32'hA000_0000 + i);
    chk("R8 blk end", 32'(blk_irq), 1);
    chk("R8 not done", 32'(xfer_done), 0);
    cpu_out(); cpu_out();
    chk("R3 fill 2", fill_of(), 2);
    chk("R6 tail", 32'(data_req), 1);
    cpu_out(); cpu_out();
    chk("R3 last of blk", cpu_rdata, 32'hA000_0007);
    chk("R6 drained", 32'(data_req), 0);
    blk_clr = 1; step(); blk_clr = 0;
    chk("R8 blk clr", 32'(blk_irq), 0);
    for (int i = 0; i < 8; i++) st_in(32'hB000_0000 + i);
    chk("R8 done", 32'(xfer_done), 1);
    chk("R8 blk2", 32'(blk_irq), 1);
    st_in(32'hDEAD_BEEF);
    chk("R8 ignored after done", fill_of(), 8);
    cpu_in(32'h1234_5678);
    chk("R9 cpu_wr ignored", fill_of(), 8);
    st_out();
    chk("R9 st_pop ignored", fill_of(), 8);
    chk("R9 no err", 32'(fifo_err), 0);
    for (int i = 0; i < 8; i++) begin
      cpu_out();
      chk("R3 order blk2", cpu_rdata, 32'hB000_0000 + i);
    end
    cpu_out();
    chk("R4 empty hold", cpu_rdata, 32'hB000_0007);
    chk("R4 empty err", 32'(fifo_err), 1);
    chk("R4 fill 0", fill_of(), 0);
    step();
    chk("R5 sticky", 32'(fifo_err), 1);
    err_clr = 1; step(); err_clr = 0;
    chk("R5 cleared", 32'(fifo_err), 0);
  endtask

  task automatic t_write_mode();
    begin_xfer(1'b0, 12'd16, 9'd1);
    chk("R7 room", 32'(data_req), 1);
    for (int i = 0; i < 12; i++) cpu_in(32'hC000_0000 + i);
    chk("R7 free 4", 32'(data_req), 1);
    cpu_in(32'hC000_000C);
    chk("R7 free 3", 32'(data_req), 0);
    for (int i = 13; i < 16; i++) cpu_in(32'hC000_0000 + i);
    chk("R2 fill field", dbg_rdata, 32'h0001_0900);
    cpu_in(32'hFFFF_0000);
    chk("R4 full fill", fill_of(), 16);
    chk("R4 full err", 32'(fifo_err), 1);
    err_clr = 1; step(); err_clr = 0;
    st_in(32'h5555_5555);
    chk("R9 st_push ignored", fill_of(), 16);
    cpu_out();
    chk("R9 cpu_rd ignored", fill_of(), 16);
    chk("R9 cpu_rd no err", 32'(fifo_err), 0);
    for (int i = 0; i < 4; i++) begin
      st_out();
      chk("R3 stream order", st_dat_out, 32'hC000_0000 + i);
    end
    chk("R8 wr done", 32'(xfer_done), 1);
    chk("R8 wr blk", 32'(blk_irq), 1);
    chk("R7 inactive", 32'(data_req), 0);
    st_out();
    chk("R8 pop ignored", fill_of(), 12);
    chk("R8 data held", st_dat_out, 32'hC000_0003);
  endtask

  task automatic t_restart();
    begin_xfer(1'b1, 12'd16, 9'd0);
    chk("R10 flush", fill_of(), 0);
    chk("R10 done clr", 32'(xfer_done), 0);
    st_in(32'h7777_7777);
    chk("R10 zero count", fill_of(), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1;
    step();
    t_reset();
    t_dbg();
    t_read_mode();
    t_write_mode();
    t_restart();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule